// File: doc/BRIEF.md
# Interrupt Occurrence Window Checker

This block is one stage of a power-on self-test. It proves that a periodic timer interrupt really reaches the logic. It does not measure how precise the timer is. A start pulse opens an observation window of fixed length, nominally 12 ms. The block then watches an asynchronous interrupt request line for a rising edge. When the window closes, the block pulses `done_o` and reports the verdict on `pass_o`. It also updates the stage's bits in an 8-bit status LED register.

The window length is a clock-cycle count. By default it is derived from the clock frequency and the window time in milliseconds. A simulation or a fast bring-up can pass a short count instead. The interrupt line goes through two synchroniser flops before any edge is detected. A start pulse that arrives while a window is open has no effect.

Top module: `irq_win_check`

## Requirements
- R1: After reset, `done_o` and `pass_o` are 0 and `led_o` is 8'h00.
- R2: A start pulse sampled while idle opens a window. From the next cycle, `led_o[6]` and `led_o[5]` read 1 and every other LED bit keeps its value.
- R3: `done_o` is high for exactly one cycle. It rises on the WINDOW_CYCLES-th rising clock edge after the edge that sampled the accepted start.
- R4: The verdict is pass (`pass_o` = 1) if at least one rising edge of `irq_i` is detected inside the window. Several edges also give a pass.
- R5: An `irq_i` that is held high across the whole window, or that only rose before the window opened, gives a fail (`pass_o` = 0).
- R6: On a pass, in the cycle `done_o` is high, `led_o[3]` becomes 1 and `led_o[6:5]` become 0.
- R7: On a fail, `led_o[6:5]` stay at 1 and `led_o[3]` keeps its previous value.
- R8: `pass_o` holds its verdict until the next accepted start, which clears it to 0.
- R9: A start pulse that arrives while a window is open is ignored. The window still closes at the time set by the first start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, opens a window when idle |
| irq_i | input | 1 | Asynchronous interrupt request under test |
| done_o | output | 1 | One-cycle pulse when the window closes |
| pass_o | output | 1 | Verdict of the last window, held |
| led_o | output | 8 | Self-test status LED bits |

## Verification
A cycle counter that is off by one moves the `done_o` pulse by one cycle. The bench sees this at the exact cycle it samples, both the cycle before and the cycle of the pulse. A seen flag that is not cleared on start turns a quiet window into a false pass at its end. A seen flag that responds to the level instead of the edge does the same with a held-high request. A timer that restarts on a second start moves the end of the window by tens of cycles. All of these show up at the end of the first window that exercises them.

// File: rtl/irq_win_pkg.sv
package irq_win_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } win_state_e;

  localparam int unsigned LED_W      = 8;
  localparam int unsigned LED_RUN_LO = 5;
  localparam int unsigned LED_RUN_HI = 6;
  localparam int unsigned LED_OK     = 3;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o) else $error("rise held"); // R4
endmodule

// File: rtl/irq_win_timer.sv
module irq_win_timer
  import irq_win_pkg::*;
#(
  parameter int unsigned WINDOW_CYCLES = 1500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o,
  output logic expire_o
);
  localparam int unsigned CNT_W = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYCLES - 1);

  win_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy_o   = (state_q == ST_RUN);
  assign expire_o = busy_o && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (load_i) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else if (expire_o) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (busy_o) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> cnt_q <= LAST) else $error("count past window"); // R3
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !expire_o |=> cnt_q == $past(cnt_q) + 1'b1) else $error("window restarted"); // R9
endmodule

// File: rtl/irq_win_check.sv
module irq_win_check
  import irq_win_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 125000000,
  parameter int unsigned WINDOW_MS     = 12,
  parameter int unsigned WINDOW_CYCLES = (CLK_HZ / 1000) * WINDOW_MS,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             irq_i,
  output logic             done_o,
  output logic             pass_o,
  output logic [LED_W-1:0] led_o
);
  logic rise, busy, expire, start_ok;
  logic seen_q, done_q, pass_q;
  logic [LED_W-1:0] led_q;

  irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (irq_i),
    .rise_o  (rise)
  );

  irq_win_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start_ok),
    .busy_o   (busy),
    .expire_o (expire)
  );

  // start while a window is open is dropped
  assign start_ok = start_i & ~busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      led_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        seen_q                      <= 1'b0;
        pass_q                      <= 1'b0;
        led_q[LED_RUN_HI:LED_RUN_LO] <= 2'b11;
      end else if (expire) begin
        done_q <= 1'b1;
        pass_q <= seen_q | rise;
        if (seen_q | rise) begin
          led_q[LED_OK]               <= 1'b1;
          led_q[LED_RUN_HI:LED_RUN_LO] <= 2'b00;
        end
      end else if (busy && rise) begin
        seen_q <= 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;
  assign led_o  = led_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done too long"); // R3
  AST_RUN_LEDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> led_o[LED_RUN_HI:LED_RUN_LO] == 2'b11) else $error("run leds"); // R2
  AST_PASS_LEDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && pass_o |-> led_o[LED_OK] && led_o[LED_RUN_HI:LED_RUN_LO] == 2'b00) else $error("pass leds"); // R6
  AST_FAIL_LEDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !pass_o |-> led_o[LED_RUN_HI:LED_RUN_LO] == 2'b11) else $error("fail leds"); // R7
  AST_PASS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pass_o) |-> done_o || $past(start_i)) else $error("verdict moved"); // R8
endmodule

// File: tb/irq_win_check_test.sv
module irq_win_check_test;
  localparam int unsigned W = 200;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       irq_i = 1'b0;
  logic       done_o, pass_o;
  logic [7:0] led_o;
  int         n_run = 0;
  int         n_fail = 0;

  always #4 clk_i = ~clk_i;

  irq_win_check #(.WINDOW_CYCLES(W)) uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .irq_i   (irq_i),
    .done_o  (done_o),
    .pass_o  (pass_o),
    .led_o   (led_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge; start sampled by next posedge; returns at following negedge (window cycle 1)
  task automatic start_pulse();
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic irq_pulse();
    irq_i = 1'b1;
    repeat (4) @(negedge clk_i);
    irq_i = 1'b0;
  endtask

  // at negedge k of the window; checks the close of the window
  task automatic finish_window(input int k, input logic exp_pass, input logic [7:0] exp_led, input string req);
    repeat (W - k) @(negedge clk_i);
    check("R3 done early", done_o, 1'b0);
    @(negedge clk_i);
    check("R3 done on time", done_o, 1'b1);
    check({req, " verdict"}, pass_o, exp_pass);
    check({req, " leds"}, led_o, exp_led);
    @(negedge clk_i);
    check("R3 done single cycle", done_o, 1'b0);
    check("R8 verdict held", pass_o, exp_pass);
  endtask

  task automatic t_reset();
    check("R1 done", done_o, 1'b0);
    check("R1 pass", pass_o, 1'b0);
    check("R1 leds", led_o, 8'h00);
  endtask

  task automatic t_single_irq();
    start_pulse();
    check("R2 run leds", led_o, 8'h60);
    repeat (30) @(negedge clk_i);
    irq_pulse();
    finish_window(35, 1'b1, 8'h08, "R4 R6");
    repeat (10) @(negedge clk_i);
    check("R8 verdict held later", pass_o, 1'b1);
  endtask

  task automatic t_quiet();
    start_pulse();
    check("R8 verdict cleared on start", pass_o, 1'b0);
    check("R2 other leds kept", led_o, 8'h68);
    finish_window(1, 1'b0, 8'h68, "R7");
  endtask

  task automatic t_level_high();
    irq_i = 1'b1;
    repeat (10) @(negedge clk_i);
    start_pulse();
    finish_window(1, 1'b0, 8'h68, "R5 held high");
    irq_i = 1'b0;
    repeat (5) @(negedge clk_i);
  endtask

  task automatic t_edge_before();
    irq_pulse();
    repeat (2) @(negedge clk_i);
    start_pulse();
    finish_window(1, 1'b0, 8'h68, "R5 edge before start");
  endtask

  task automatic t_multi_irq();
    start_pulse();
    repeat (10) @(negedge clk_i);
    irq_pulse();
    repeat (20) @(negedge clk_i);
    irq_pulse();
    finish_window(39, 1'b1, 8'h08, "R4 several edges");
  endtask

  task automatic t_restart();
    start_pulse();
    repeat (20) @(negedge clk_i);
    irq_pulse();
    repeat (24) @(negedge clk_i);
    start_pulse();
    check("R9 leds during window", led_o, 8'h68);
    finish_window(50, 1'b1, 8'h08, "R9 restart ignored");
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_single_irq();
    t_quiet();
    t_level_high();
    t_edge_before();
    t_multi_irq();
    t_restart();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk_i);
        n_run++;
        n_fail++;
        $display("FAIL R3 watchdog: actual hung expected done");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule